// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects thirty-two interrupt sources and drives one interrupt request line to a host processor. Sources 0 to 3 come from external pins. Each of these pins can be set to latch a rising edge or to follow the pin level. Sources 4 to 31 are internal event lines and are always level sensitive. Each source has a pending bit and an enable (mask) bit. The host line is high whenever at least one pending source is also enabled.

Arbitration has three stages:
- The sources are split into six groups.
- A programmable order register ranks the groups.
- Inside a group, the lowest source index wins.

Software can also name one source as promoted. While that source is pending and enabled, it beats every other source.

The host reads the vector register to learn the winning source number. The same read acknowledges an edge-latched source by clearing its pending bit.

Top module: `gpic_top`

## Requirements
- R1: After reset the following values hold. The mask register reads 0, so all sources are disabled. All external inputs are level sensitive. No source is promoted (the promote register reads 0). The `irq` output is low. `rdata` is 0. The order register reads the identity order, which is the value 181896.
- R2: Internal sources, and external sources set to level mode, show their input value in their pending bit one clock after the input is sampled.
- R3: Sense bit e of the sense register (address 2) selects the mode of external source e: 1 means edge, 0 means level.
  - An edge-mode source sets its pending bit on a rising input.
  - The bit stays set after the input falls.
  - Writing a 1 to that bit of the pending register (address 1) clears it.
  - Such a write has no effect on level-mode bits.
- R4: A source whose mask bit (address 0, bit i = source i, 1 = enabled) is 0 still shows its pending bit. It never raises `irq` and never wins arbitration, even when it is the promoted source.
- R5: `irq` is high exactly when some source is both pending and enabled. It falls in the cycle after the last such source clears.
- R6: Among the enabled pending sources of the same group, the lowest index wins.
- R7: The order register (address 3) holds six 3-bit entries. Entry k sits at bits 3k+2:3k, and entry 0 has the highest rank. The winning group is the first entry, in rank order, whose group has an enabled pending source. An entry value of 6 or 7 matches no group.
- R8: The promote register (address 4) has a valid flag in bit 5 and a source index in bits 4:0. While the promoted source is pending and enabled, it wins over all groups.
- R9: A read of the vector register (address 5) returns the winner's index on `rdata` one cycle later, or 63 when nothing is enabled and pending. In the same cycle, the read clears the winner's edge-latched pending bit.
- R10: Source i belongs to group floor(i/6). Group 5 therefore holds only sources 30 and 31.
- R11: Register reads are registered.
  - Addresses 0 to 4 return the stored register contents, zero-extended.
  - Address 1 returns the pending bits.
  - Addresses 6 and 7 read 0.
  - `rdata` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 4 | External interrupt pins, sources 0..3 |
| int_in | input | 28 | Internal event lines, sources 4..31 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Request to the host processor |

## Verification
Several active patterns are used, each aimed at one stage of the arbitration:
- Two sources in one group show whether the lowest index wins inside the group.
- A pair that straddles a group boundary (11 and 12), read under two order settings, shows where the group boundaries lie.
- A low-index source paired with source 30, with group 5 ranked first, shows that the order register, not the index, ranks the groups.
- A masked promoted source separates the masking rule from the promotion rule.

Single pulses on an edge-mode pin, compared with held levels on a level-mode pin, show latch versus follow behaviour and the reach of acknowledge and write-to-clear. A long run of random inputs, register writes and reads is then compared every clock against a behavioural model.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  typedef enum logic [2:0] {
    A_MASK  = 3'd0,
    A_PEND  = 3'd1,
    A_SENSE = 3'd2,
    A_ORDER = 3'd3,
    A_PROMO = 3'd4,
    A_VECT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpic_capture.sv
module gpic_capture #(
  parameter int NSRC = 32,
  parameter int NEXT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEXT-1:0]   ext_in,
  input  logic [NSRC-NEXT-1:0] int_in,
  input  logic [NEXT-1:0]   edge_mode,
  input  logic [NEXT-1:0]   clr,
  output logic [NSRC-1:0]   pend
);
  logic [NEXT-1:0]      prev_q;
  logic [NEXT-1:0]      pend_ext_q;
  logic [NSRC-NEXT-1:0] pend_int_q;
  logic                 live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      pend_ext_q <= '0;
      pend_int_q <= '0;
      live_q     <= 1'b0;
    end else begin
      prev_q     <= ext_in;
      pend_int_q <= int_in;
      live_q     <= 1'b1;
      for (int e = 0; e < NEXT; e++) begin
        if (edge_mode[e]) begin
          if (ext_in[e] && !prev_q[e]) pend_ext_q[e] <= 1'b1;
          else if (clr[e])             pend_ext_q[e] <= 1'b0;
        end else begin
          pend_ext_q[e] <= ext_in[e];
        end
      end
    end
  end

  assign pend = {pend_int_q, pend_ext_q};

  // R2
  int_follow_chk: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (pend[NSRC-1:NEXT] == $past(int_in)));

  for (genvar e = 0; e < NEXT; e++) begin : g_hold
    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_mode[e] && pend[e] && !clr[e]) |=> (pend[e] || !edge_mode[e]));
  end
endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter #(
  parameter int NSRC = 32,
  parameter int NGRP = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NSRC-1:0]                active,
  input  logic [NGRP*$clog2(NGRP)-1:0]   order,
  input  logic                           prom_vld,
  input  logic [$clog2(NSRC)-1:0]        prom_idx,
  output logic                           win_vld,
  output logic [$clog2(NSRC)-1:0]        win_idx
);
  localparam int GSIZE  = (NSRC + NGRP - 1) / NGRP;
  localparam int ORD_W  = $clog2(NGRP);
  localparam int SIDX_W = $clog2(NSRC);

  logic              g_any [NGRP];
  logic [SIDX_W-1:0] g_low [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      g_any[g] = 1'b0;
      g_low[g] = '0;
      for (int j = GSIZE - 1; j >= 0; j--) begin
        if (g * GSIZE + j < NSRC) begin
          if (active[(g * GSIZE + j) % NSRC]) begin
            g_any[g] = 1'b1;
            g_low[g] = SIDX_W'((g * GSIZE + j) % NSRC);
          end
        end
      end
    end
  end

  always_comb begin
    logic [ORD_W-1:0] grp;
    win_vld = 1'b0;
    win_idx = '0;
    for (int k = NGRP - 1; k >= 0; k--) begin
      grp = order[k*ORD_W +: ORD_W];
      if (int'(grp) < NGRP) begin
        if (g_any[int'(grp) % NGRP]) begin
          win_vld = 1'b1;
          win_idx = g_low[int'(grp) % NGRP];
        end
      end
    end
    if (prom_vld && active[prom_idx]) begin
      win_vld = 1'b1;
      win_idx = prom_idx;
    end
  end

  // R8
  prom_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (prom_vld && active[prom_idx]) |-> (win_vld && win_idx == prom_idx));

  // R4
  win_active_chk: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> active[win_idx]);

  // R9
  none_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |-> !win_vld);
endmodule

// File: rtl/gpic_top.sv
module gpic_top #(
  parameter int NSRC = 32,
  parameter int NEXT = 4,
  parameter int NGRP = 6,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NEXT-1:0]      ext_in,
  input  logic [NSRC-NEXT-1:0] int_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [2:0]           addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic                 irq
);
  import gpic_pkg::*;

  localparam int ORD_W  = $clog2(NGRP);
  localparam int SIDX_W = $clog2(NSRC);
  localparam int VEC_W  = SIDX_W + 1;
  localparam logic [VEC_W-1:0] NONE = {VEC_W{1'b1}};

  function automatic logic [NGRP*ORD_W-1:0] ident_order();
    logic [NGRP*ORD_W-1:0] r;
    r = '0;
    for (int k = 0; k < NGRP; k++) r[k*ORD_W +: ORD_W] = ORD_W'(k);
    return r;
  endfunction

  logic [NSRC-1:0]       mask_q;
  logic [NEXT-1:0]       sense_q;
  logic [NGRP*ORD_W-1:0] order_q;
  logic [SIDX_W:0]       prom_q;
  logic [DW-1:0]         rdata_q;
  logic [NSRC-1:0]       pend;
  logic [NEXT-1:0]       clr_ext;
  logic                  win_vld;
  logic [SIDX_W-1:0]     win_idx;
  logic                  vect_rd;

  assign vect_rd = rd_en && (addr == A_VECT);

  always_comb begin
    clr_ext = '0;
    if (wr_en && addr == A_PEND) clr_ext = wdata[NEXT-1:0];
    if (vect_rd && win_vld)
      for (int e = 0; e < NEXT; e++)
        if (win_idx == SIDX_W'(e)) clr_ext[e] = 1'b1;
  end

  gpic_capture #(.NSRC(NSRC), .NEXT(NEXT)) u_cap (
    .clk(clk), .rst(rst), .ext_in(ext_in), .int_in(int_in),
    .edge_mode(sense_q), .clr(clr_ext), .pend(pend)
  );

  gpic_arbiter #(.NSRC(NSRC), .NGRP(NGRP)) u_arb (
    .clk(clk), .rst(rst), .active(pend & mask_q), .order(order_q),
    .prom_vld(prom_q[SIDX_W]), .prom_idx(prom_q[SIDX_W-1:0]),
    .win_vld(win_vld), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      sense_q <= '0;
      order_q <= ident_order();
      prom_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MASK:  mask_q  <= wdata[NSRC-1:0];
        A_SENSE: sense_q <= wdata[NEXT-1:0];
        A_ORDER: order_q <= wdata[NGRP*ORD_W-1:0];
        A_PROMO: prom_q  <= wdata[SIDX_W:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (addr)
        A_MASK:  rdata_q <= DW'(mask_q);
        A_PEND:  rdata_q <= DW'(pend);
        A_SENSE: rdata_q <= DW'(sense_q);
        A_ORDER: rdata_q <= DW'(order_q);
        A_PROMO: rdata_q <= DW'(prom_q);
        A_VECT:  rdata_q <= win_vld ? DW'(win_idx) : DW'(NONE);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign irq   = |(pend & mask_q);

  // R5
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    !irq |-> !win_vld);

  // R9
  vect_none_chk: assert property (@(posedge clk) disable iff (rst)
    (vect_rd && !irq) |=> (rdata == DW'(NONE)));
endmodule

// File: tb/sim_gpic_top.sv
module sim_gpic_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ext_in = '0;
  logic [27:0] int_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  gpic_top u0 (
    .clk(clk), .rst(rst), .ext_in(ext_in), .int_in(int_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit [31:0] m_pend, m_mask, m_rdata;
  bit [3:0]  m_sense, m_prev;
  int        m_order [6];
  bit        m_pv;
  int        m_pidx;

  function automatic int m_win();
    bit [31:0] act = m_pend & m_mask;
    if (m_pv && act[m_pidx]) return m_pidx;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 32; i++)
        if (i / 6 == m_order[k] && act[i]) return i;
    return 63;
  endfunction

  function automatic bit [31:0] m_order_word();
    bit [31:0] v = 0;
    for (int k = 0; k < 6; k++) v |= 32'(m_order[k]) << (3 * k);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_mask = 0; m_rdata = 0; m_sense = 0; m_prev = 0;
      m_pv = 0; m_pidx = 0;
      for (int k = 0; k < 6; k++) m_order[k] = k;
    end else begin
      int w;
      bit [31:0] np;
      w = m_win();
      if (rd_en) begin
        case (addr)
          0: m_rdata = m_mask;
          1: m_rdata = m_pend;
          2: m_rdata = {28'b0, m_sense};
          3: m_rdata = m_order_word();
          4: m_rdata = {26'b0, m_pv, 5'(m_pidx)};
          5: m_rdata = 32'(w);
          default: m_rdata = 0;
        endcase
      end
      np = m_pend;
      for (int i = 0; i < 32; i++) begin
        if (i < 4 && m_sense[i]) begin
          if (wr_en && addr == 1 && wdata[i]) np[i] = 0;
          if (rd_en && addr == 5 && w == i) np[i] = 0;
          if (ext_in[i] && !m_prev[i]) np[i] = 1;
        end else begin
          np[i] = (i < 4) ? ext_in[i] : int_in[i-4];
        end
      end
      m_pend = np;
      m_prev = ext_in;
      if (wr_en) begin
        case (addr)
          0: m_mask = wdata;
          2: m_sense = wdata[3:0];
          3: for (int k = 0; k < 6; k++) m_order[k] = int'((wdata >> (3 * k)) & 7);
          4: begin m_pv = wdata[5]; m_pidx = int'(wdata[4:0]); end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 irq vs model", 32'(irq), 32'(|(m_pend & m_mask)));
      check("R11 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; addr = 3'(a); wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    rd_en = 1'b1; addr = 3'(a);
    tick();
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 rdata", rdata, 0);
    rd(0, v); check("R1 mask", v, 0);
    rd(2, v); check("R1 sense", v, 0);
    rd(3, v); check("R1 order", v, 181896);
    rd(4, v); check("R1 promote", v, 0);
    rd(5, v); check("R9 none code", v, 63);
    rd(6, v); check("R11 unused addr", v, 0);
    // R2 / R4: masked internal source 10
    int_in[6] = 1'b1;
    tick(); tick();
    rd(1, v); check("R2 pending follows", v, 32'h400);
    check("R4 masked no irq", 32'(irq), 0);
    rd(5, v); check("R4 masked no winner", v, 63);
    wr(0, 32'hFFFF_FFFF);
    check("R5 irq on enable", 32'(irq), 1);
    rd(5, v); check("R9 vector", v, 10);
    // R6 lowest in group 1
    int_in[4] = 1'b1; tick();
    rd(5, v); check("R6 lowest index", v, 8);
    // R10 boundary 11 / 12
    int_in = '0; int_in[7] = 1'b1; int_in[8] = 1'b1; tick();
    wr(3, 181889);
    rd(5, v); check("R10 group1 first", v, 11);
    wr(3, 181826);
    rd(5, v); check("R10 group2 first", v, 12);
    // R7 group order
    int_in = '0; int_in[6] = 1'b1; int_in[26] = 1'b1;
    wr(3, 181896);
    rd(5, v); check("R7 identity order", v, 10);
    wr(3, 144453);
    rd(5, v); check("R7 group5 first", v, 30);
    // R8 promotion
    wr(3, 181896);
    int_in[27] = 1'b1;
    wr(4, 63);
    rd(5, v); check("R8 promoted wins", v, 31);
    wr(0, 32'h7FFF_FFFF);
    rd(5, v); check("R4 masked promoted loses", v, 10);
    rd(4, v); check("R11 promote readback", v, 63);
    // R5 drop
    wr(0, 32'hFFFF_FFFF);
    wr(4, 0);
    int_in = '0;
    tick();
    check("R5 irq drops", 32'(irq), 0);
    // R3 edge capture on ext 0
    wr(2, 1);
    rd(2, v); check("R11 sense readback", v, 1);
    ext_in[0] = 1'b1; tick();
    ext_in[0] = 1'b0; tick(); tick();
    rd(1, v); check("R3 edge latched", v, 1);
    check("R3 irq from latch", 32'(irq), 1);
    rd(5, v); check("R9 vector edge", v, 0);
    rd(1, v); check("R9 ack clears", v, 0);
    ext_in[0] = 1'b1; tick();
    ext_in[0] = 1'b0; tick();
    wr(1, 1);
    rd(1, v); check("R3 write clears", v, 0);
    ext_in[1] = 1'b1; tick();
    wr(1, 2);
    rd(1, v); check("R3 level ignores clear", v, 2);
    ext_in[1] = 1'b0; tick();
    rd(1, v); check("R2 level ext follows", v, 0);
    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) ext_in = 4'($urandom);
      if ($urandom_range(0, 3) == 0) int_in = 28'($urandom) & 28'($urandom);
      wr_en = ($urandom_range(0, 5) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      addr  = 3'($urandom_range(0, 7));
      wdata = $urandom;
      if (wr_en && addr == 3'd5) addr = 3'd0;
      tick();
    end
    wr_en = 1'b0; rd_en = 1'b0;
    tick();
    finish_run();
  end
endmodule